// File: doc/BRIEF.md
# Synchronous Tag Memory with Lookup Comparator

This block is a clocked single-port tag store for cache directories. Every synchronous control, the address and the shared data bus are sampled on the rising clock edge. A selected cycle either stores the held data word at the sampled address, or reads that location and compares it across the full word width against the held data word. The comparison result passes through one pipeline flop before it reaches the hit pin, so a lookup issued at edge k shows its verdict after edge k+1.

One bidirectional bus carries write data into the block and read data out of it. Two select inputs of opposite polarity allow several banks to share a bus for depth expansion. The read-data drive and the hit-pin drive each have their own enable. Both enables act at once, without waiting for a clock edge. The held data word reloads only on cycles that ask for it. A controller can therefore keep one probe tag and sweep it across many addresses.

Top module: `tagram_top`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits. Every address from 0 to 2^ADDR_W-1 is a distinct location. Defaults are ADDR_W=10 and DATA_W=18; ADDR_W=16 gives the full 64K-word depth.
- R2: The address, bus data, `sel_n`, `sel`, `wr` and `ld` are sampled on the rising edge of `clk`. A cycle is selected only when `sel_n`=0 and `sel`=1 at that edge. Any other combination is an idle cycle, and an idle cycle neither writes nor looks up.
- R3: The held data word is loaded from `dq` only when `ld`=1 at an edge that selects the block. At every other edge it keeps its value.
- R4: A selected cycle with `wr`=1 at edge k stores the held data word (after that edge's load) into the sampled address at edge k+1.
- R5: A selected cycle with `wr`=0 at edge k compares the addressed word with the held data word over all DATA_W bits. After edge k+1 the registered hit is 1 if and only if every bit matches, so a single differing bit gives 0.
- R6: The block drives `dq` with the addressed word only during the clock period that follows a lookup edge, and only while `oe`=1. At all other times `dq` is high-impedance. `oe` takes effect combinationally.
- R7: `hit` carries the registered hit while `hit_oe`=1 and is high-impedance while `hit_oe`=0. `hit_oe` takes effect combinationally.
- R8: An idle edge or a write edge clears the registered hit at the following edge.
- R9: With `rst`=1 at an edge, that edge clears the sampled address, the held data word, the cycle type and the registered hit to zero or idle. Memory contents stay unchanged.
- R10: A lookup issued on the edge right after a write to the same address sees the newly written word, both on `dq` and in the compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the registers |
| addr | input | ADDR_W | Word address, sampled each edge |
| dq | inout | DATA_W | Shared bus: write/probe data in, read data out |
| sel_n | input | 1 | Active-low bank select |
| sel | input | 1 | Active-high bank select |
| wr | input | 1 | 1 = write cycle, 0 = lookup cycle |
| ld | input | 1 | Load enable for the held data word |
| oe | input | 1 | Asynchronous read-data drive enable |
| hit_oe | input | 1 | Asynchronous hit-pin drive enable |
| hit | output | 1 | Registered compare result, tri-stated by `hit_oe` |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=18 and SLICE_W=5. With 64 words the bench can fill the whole array and probe both the lowest and the highest address. A width of 18 split into slices of 5 leaves a narrower last slice of 3 bits. Single-bit misses at bit 0, bit 10 and bit 17 therefore land in a full first slice, an inner slice and the short final slice. Weak pull-ups on the bus and the hit pin turn high-impedance into an all-ones value that the bench can observe.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_LOOKUP = 2'd2
   } tag_op_e;

   function automatic logic bank_selected(input logic sel_lo_n, input logic sel_hi);
      return (!sel_lo_n) && sel_hi;
   endfunction

   function automatic tag_op_e decode_op(input logic selected, input logic wr_req);
      if (!selected) return OP_IDLE;
      return wr_req ? OP_WRITE : OP_LOOKUP;
   endfunction

endpackage

// File: rtl/tagram_inreg.sv
module tagram_inreg
   import tagram_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          sel_n_i,
   input  logic          sel_i,
   input  logic          wr_i,
   input  logic          ld_i,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] data_q,
   output tag_op_e       op_q
);

   logic    selected;
   tag_op_e op_d;

   always_comb begin
      selected = bank_selected(sel_n_i, sel_i);
      op_d     = decode_op(selected, wr_i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         data_q <= '0;
         op_q   <= OP_IDLE;
      end else begin
         addr_q <= addr_i;
         op_q   <= op_d;
         if (ld_i && selected) begin
            data_q <= data_i;
         end
      end
   end

endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
   parameter int AW = 10,
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store[wr_addr] <= wr_data;
      end
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp #(
   parameter int DW      = 18,
   parameter int SLICE_W = 6
) (
   input  logic [DW-1:0] word_a,
   input  logic [DW-1:0] word_b,
   output logic          equal
);

   localparam int NSLICE = (DW + SLICE_W - 1) / SLICE_W;

   logic [NSLICE-1:0] slice_eq;

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      localparam int LO = s * SLICE_W;
      localparam int HI = ((LO + SLICE_W) > DW) ? (DW - 1) : (LO + SLICE_W - 1);
      assign slice_eq[s] = (word_a[HI:LO] == word_b[HI:LO]);
   end

   assign equal = &slice_eq;

endmodule

// File: rtl/tagram_outstage.sv
module tagram_outstage
   import tagram_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  tag_op_e op_q,
   input  logic    equal,
   input  logic    oe_i,
   input  logic    hit_oe_i,
   output logic    hit_q,
   output logic    dq_drv,
   output logic    hit_drv
);

   logic lookup_now;

   assign lookup_now = (op_q == OP_LOOKUP);

   always_ff @(posedge clk) begin
      if (rst) begin
         hit_q <= 1'b0;
      end else begin
         hit_q <= lookup_now && equal;
      end
   end

   assign dq_drv  = oe_i && lookup_now;
   assign hit_drv = hit_oe_i;

endmodule

// File: rtl/tagram_top.sv
module tagram_top
   import tagram_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 18,
   parameter int SLICE_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [DATA_W-1:0] dq,
   input  logic              sel_n,
   input  logic              sel,
   input  logic              wr,
   input  logic              ld,
   input  logic              oe,
   input  logic              hit_oe,
   output logic              hit
);

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_aw
      $error("tagram_top: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("tagram_top: DATA_W must be positive");
   end
   if (SLICE_W < 1 || SLICE_W > DATA_W) begin : g_bad_slice
      $error("tagram_top: SLICE_W must lie in 1..DATA_W");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   tag_op_e           op_q;
   logic [DATA_W-1:0] rd_word;
   logic              equal;
   logic              hit_q;
   logic              dq_drv;
   logic              hit_drv;
   logic              wr_en;

   tagram_inreg #(.AW(ADDR_W), .DW(DATA_W)) u_inreg (
      .clk     (clk),
      .rst     (rst),
      .addr_i  (addr),
      .data_i  (dq),
      .sel_n_i (sel_n),
      .sel_i   (sel),
      .wr_i    (wr),
      .ld_i    (ld),
      .addr_q  (addr_q),
      .data_q  (data_q),
      .op_q    (op_q)
   );

   assign wr_en = (op_q == OP_WRITE);

   tagram_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (addr_q),
      .wr_data (data_q),
      .rd_addr (addr_q),
      .rd_data (rd_word)
   );

   tagram_cmp #(.DW(DATA_W), .SLICE_W(SLICE_W)) u_cmp (
      .word_a (rd_word),
      .word_b (data_q),
      .equal  (equal)
   );

   tagram_outstage u_out (
      .clk      (clk),
      .rst      (rst),
      .op_q     (op_q),
      .equal    (equal),
      .oe_i     (oe),
      .hit_oe_i (hit_oe),
      .hit_q    (hit_q),
      .dq_drv   (dq_drv),
      .hit_drv  (hit_drv)
   );

   assign dq  = dq_drv  ? rd_word : {DATA_W{1'bz}};
   assign hit = hit_drv ? hit_q   : 1'bz;

endmodule

// File: rtl/tagram_chk.sv
module tagram_chk
   import tagram_pkg::*;
#(
   parameter int DW = 18
) (
   input logic          clk,
   input logic          rst,
   input logic          sel_n,
   input logic          sel,
   input logic          ld,
   input logic          hit_oe,
   input tag_op_e       op_q,
   input logic [DW-1:0] data_q,
   input logic          hit_q,
   input logic          dq_drv,
   input logic          hit_drv
);

   p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
      !(ld && !sel_n && sel) |=> $stable(data_q));

   p_hit_from_lookup_r5: assert property (@(posedge clk) disable iff (rst)
      hit_q |-> $past(op_q == OP_LOOKUP));

   p_no_drive_on_write_r6: assert property (@(posedge clk) disable iff (rst)
      (op_q != OP_LOOKUP) |-> !dq_drv);

   p_hit_pin_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !hit_oe |-> !hit_drv);

   p_clear_after_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (op_q != OP_LOOKUP) |=> !hit_q);

   p_reset_clears_r9: assert property (@(posedge clk)
      rst |=> (!hit_q && op_q == OP_IDLE && data_q == '0));

endmodule

bind tagram_top tagram_chk #(.DW(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .sel_n   (sel_n),
   .sel     (sel),
   .ld      (ld),
   .hit_oe  (hit_oe),
   .op_q    (op_q),
   .data_q  (data_q),
   .hit_q   (hit_q),
   .dq_drv  (dq_drv),
   .hit_drv (hit_drv)
);

// File: tb/tagram_top_tb_top.sv
module tagram_top_tb_top;

   localparam int AW = 6;
   localparam int DW = 18;
   localparam int SW = 5;
   localparam int NWORDS = 1 << AW;
   localparam int NVEC = 10;
   localparam logic [DW-1:0] ONES = {DW{1'b1}};

   // each entry: {address, bit flips applied to the stored word, expected hit}
   localparam logic [AW+DW:0] VEC [NVEC] = '{
      {6'd0,  18'h00000, 1'b1},
      {6'd63, 18'h00000, 1'b1},
      {6'd1,  18'h00001, 1'b0},
      {6'd2,  18'h20000, 1'b0},
      {6'd17, 18'h00000, 1'b1},
      {6'd33, 18'h3ffff, 1'b0},
      {6'd40, 18'h00400, 1'b0},
      {6'd9,  18'h00000, 1'b1},
      {6'd62, 18'h00000, 1'b1},
      {6'd31, 18'h10001, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          sel_n = 1'b1;
   logic          sel = 1'b0;
   logic          wr = 1'b0;
   logic          ld = 1'b0;
   logic          oe = 1'b0;
   logic          hit_oe = 1'b1;
   logic          tb_drv = 1'b0;
   logic [DW-1:0] tb_val = '0;
   wire  [DW-1:0] dq;
   wire           hit;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] model [NWORDS];

   always #2 clk = ~clk;   // 4 ns period at 1 ns units

   assign dq = tb_drv ? tb_val : {DW{1'bz}};
   for (genvar b = 0; b < DW; b++) begin : g_pu
      pullup (dq[b]);
   end
   pullup (hit);

   tagram_top #(.ADDR_W(AW), .DATA_W(DW), .SLICE_W(SW)) dut_i (
      .clk    (clk),
      .rst    (rst),
      .addr   (addr),
      .dq     (dq),
      .sel_n  (sel_n),
      .sel    (sel),
      .wr     (wr),
      .ld     (ld),
      .oe     (oe),
      .hit_oe (hit_oe),
      .hit    (hit)
   );

   function automatic logic [DW-1:0] word_of(input int a);
      logic [15:0] low;
      low = 16'((a * 16'h09e3) + 16'h0051);
      return {2'b01, low};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   task automatic go_idle();
      sel_n = 1'b1; sel = 1'b0; wr = 1'b0; ld = 1'b0; tb_drv = 1'b0;
   endtask

   task automatic cycle_in(input logic [AW-1:0] a, input logic sn, input logic s,
                           input logic w, input logic l, input logic [DW-1:0] v);
      @(negedge clk);
      addr = a; sel_n = sn; sel = s; wr = w; ld = l;
      tb_drv = 1'b1; tb_val = v; oe = 1'b0;
   endtask

   task automatic write_word(input int a, input logic [DW-1:0] v);
      cycle_in(AW'(a), 1'b0, 1'b1, 1'b1, 1'b1, v);
      model[a] = v;
   endtask

   // lookup at edge k; bus seen in the following period, hit after edge k+1
   task automatic lookup(input int a, input logic [DW-1:0] tag, input logic l,
                         output logic [DW-1:0] bus_off, output logic [DW-1:0] bus_on,
                         output logic hit_seen);
      cycle_in(AW'(a), 1'b0, 1'b1, 1'b0, l, tag);
      @(negedge clk);
      go_idle();
      #0.5;
      bus_off = dq;
      oe = 1'b1;
      #0.5;
      bus_on = dq;
      oe = 1'b0;
      @(negedge clk);
      hit_seen = hit;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end

   initial begin
      logic [DW-1:0] off_v;
      logic [DW-1:0] on_v;
      logic          h;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R9 reset hit", 32'(hit), 32'h0);
      oe = 1'b1;
      #0.5;
      check("R6 idle bus tri-state", 32'(dq), 32'(ONES));
      oe = 1'b0;

      for (int a = 0; a < NWORDS; a++) begin
         write_word(a, word_of(a));
      end

      // table walk (R1 R4 R5 R6)
      for (int i = 0; i < NVEC; i++) begin
         int            va;
         logic [DW-1:0] vm;
         logic          vh;
         va = int'(VEC[i][AW+DW:DW+1]);
         vm = VEC[i][DW:1];
         vh = VEC[i][0];
         lookup(va, model[va] ^ vm, 1'b1, off_v, on_v, h);
         check("R6 bus off while oe low", 32'(off_v), 32'(ONES));
         check("R1 R4 read word", 32'(on_v), 32'(model[va]));
         check("R5 table hit", 32'(h), 32'(vh));
      end

      // R5 miss in inner slice bit 10
      lookup(12, model[12] ^ 18'h00400, 1'b1, off_v, on_v, h);
      check("R5 inner bit miss", 32'(h), 32'h0);

      // R3 ld low keeps previous probe
      lookup(20, model[20], 1'b1, off_v, on_v, h);
      check("R3 loaded probe hit", 32'(h), 32'h1);
      lookup(20, 18'h0beef, 1'b0, off_v, on_v, h);
      check("R3 held probe hit", 32'(h), 32'h1);

      // R2 R3 half-selected cycle: no write, no probe load
      cycle_in(AW'(5), 1'b0, 1'b0, 1'b1, 1'b1, 18'h00aaa);
      cycle_in(AW'(5), 1'b1, 1'b1, 1'b1, 1'b1, 18'h00bbb);
      lookup(20, 18'h00ccc, 1'b0, off_v, on_v, h);
      check("R2 R3 half select leaves probe", 32'(h), 32'h1);
      lookup(5, model[5], 1'b1, off_v, on_v, h);
      check("R2 half select no write bus", 32'(on_v), 32'(model[5]));
      check("R2 half select no write hit", 32'(h), 32'h1);

      // R8 idle clears hit next edge
      @(negedge clk);
      check("R8 idle clears hit", 32'(hit), 32'h0);

      // R8 write after hit clears hit
      cycle_in(AW'(7), 1'b0, 1'b1, 1'b0, 1'b1, model[7]);
      write_word(8, 18'h12345);
      @(negedge clk);
      go_idle();
      check("R5 hit before write", 32'(hit), 32'h1);
      @(negedge clk);
      check("R8 write clears hit", 32'(hit), 32'h0);

      // R10 read right after write, same address
      write_word(44, 18'h15a5a);
      lookup(44, 18'h15a5a, 1'b1, off_v, on_v, h);
      check("R10 raw bus", 32'(on_v), 32'h15a5a);
      check("R10 raw hit", 32'(h), 32'h1);

      // R7 hit pin enable, on a miss
      lookup(3, model[3] ^ 18'h00002, 1'b1, off_v, on_v, h);
      check("R7 miss driven", 32'(h), 32'h0);
      hit_oe = 1'b0;
      #0.5;
      check("R7 hit pin tri-state", 32'(hit), 32'h1);
      hit_oe = 1'b1;
      #0.5;
      check("R7 hit pin driven again", 32'(hit), 32'h0);

      // R9 mid-run reset keeps array, clears probe and hit
      cycle_in(AW'(9), 1'b0, 1'b1, 1'b0, 1'b1, model[9]);
      @(negedge clk);
      go_idle();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R9 reset clears hit", 32'(hit), 32'h0);
      lookup(9, 18'h3f00f, 1'b0, off_v, on_v, h);
      check("R9 probe cleared", 32'(h), 32'h0);
      check("R9 array kept", 32'(on_v), 32'(model[9]));
      lookup(9, model[9], 1'b1, off_v, on_v, h);
      check("R9 array kept hit", 32'(h), 32'h1);

      summary();
   end

endmodule